// File: doc/BRIEF.md
# Memory-Mapped I2C Single-Byte Command Engine

This block lets a host CPU move one byte to or from a register of a device on an I2C bus, through a small set of 32-bit memory-mapped registers. Software writes a packed setup word that chooses the opcode, the device address and the register index. It loads the message buffer, then sets a start bit in the control register. The engine latches the command, hands one transaction to the I2C bus side and waits for the response. When the transfer ends it clears the start bit. The outcome is reported in a status register.

The register bus carries its data in the opposite byte order to the logical register layout, so every register access is byte-reversed at the boundary. A store made through one of two address aliases is applied as a read-modify-write: one alias ANDs the data into the target register and the other ORs it in. This lets software set or clear single bits without a read.

The I2C side is a pair of valid/ready channels. A request channel carries the decoded command to a bit-level engine outside this block, and a response channel carries back the NACK flag and any byte that was read. The request holds `txn_valid` and all its fields stable until `txn_ready` is seen high at a clock edge. The response is accepted only on an edge where both `rsp_valid` and `rsp_ready` are high. `rsp_ready` is high only while the engine is waiting for a response, so the far side may hold `rsp_valid` for as long as it needs to.

Top module: `i2ce_top`

## Requirements
- R1: The register bus is byte-reversed relative to the logical layout, on both stores and loads. Logical byte 0 travels on `bus_wdata[31:24]` and `bus_rdata[31:24]`, and logical byte 3 travels on bits 7:0.
- R2: The logical registers are message buffer 0x008, setup 0x010, control 0x020, parameter 0x040 and status 0x070. A store to an offset with address bits 13:12 = 00 replaces the register. Bits 13:12 = 01 ANDs the data in, and 10 ORs it in. A store with bits 13:12 = 11 is ignored, and stores to status are ignored.
- R3: The setup word bits 31:16 select the opcode: 0x0001 is read at address, 0x4001 is write at address, 0x1001 is read direct and 0x6001 is write direct. The at-address forms send the device address from bits 14:8 and the index from bits 7:0. The direct forms send the index from bits 15:8, device address 0, and ignore bits 7:0.
- R4: Setting logical control bit 1 while idle launches a transfer. The bit reads 1 until the transfer completes and then clears by itself. Status bit 0 mirrors it, and status bit 3 is set on completion.
- R5: The setup word and the low buffer byte are captured at launch. Stores to them during a transfer do not change the transfer that is running.
- R6: A start request made while a transfer is in progress is ignored and produces no further transaction.
- R7: On a write, the transaction byte is the low byte of the message buffer. On a successful read, the returned byte replaces buffer bits 7:0 and bits 31:8 keep their value.
- R8: A NACK response sets status bit 2, which is inside error mask 0x00000A76. It still clears the start bit and leaves the buffer unchanged.
- R9: An unrecognised opcode sets status bit 9, issues no transaction and clears the start bit on the next clock edge.
- R10: Status error bits stay set until the next launch, which clears them together with the done bit.
- R11: While `txn_valid` is high and `txn_ready` is low, the request fields hold steady. `rsp_ready` is high only while the request has been taken and the response is not yet in.
- R12: After reset every register reads 0, and `txn_valid` and `rsp_ready` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Store strobe for one cycle |
| bus_addr | input | 14 | Byte address: alias in bits 13:12, offset in bits 11:0 |
| bus_wdata | input | 32 | Store data in bus byte order |
| bus_rdata | output | 32 | Load data for `bus_addr`, bus byte order, combinational |
| txn_valid | output | 1 | Request to the I2C side is valid |
| txn_ready | input | 1 | I2C side takes the request |
| txn_read | output | 1 | 1 for a read transfer, 0 for a write |
| txn_direct | output | 1 | 1 for a direct form without a device address phase |
| txn_dev | output | 7 | 7-bit device address |
| txn_index | output | 8 | Register index inside the device |
| txn_wbyte | output | 8 | Byte to write |
| rsp_valid | input | 1 | Response from the I2C side is valid |
| rsp_ready | output | 1 | Engine accepts a response |
| rsp_nack | input | 1 | Device did not acknowledge |
| rsp_rbyte | input | 8 | Byte returned by a read |

## Verification
Assertions watch the handshakes on every cycle. They check that request fields hold under back-pressure, that the request and response channels are never open together, and that the start bit is set whenever a transaction is in flight. They also check that a finished transfer always drops the start bit, that a NACK always lands in status and that error bits never fall without a launch. The bench scenarios cover what a per-cycle property cannot see. These are the field packing of each opcode, the byte reversal against fixed bus values, and the AND and OR alias results. They also cover capture of the setup word at launch, the ignored second start, the unrecognised-opcode path and the buffer update after a read.

// File: rtl/i2ce_pkg.sv
package i2ce_pkg;

  typedef enum logic [1:0] {
    ST_PLAIN = 2'b00,
    ST_AND   = 2'b01,
    ST_OR    = 2'b10,
    ST_NONE  = 2'b11
  } store_op_e;

  typedef struct packed {
    logic       is_read;
    logic       direct;
    logic [6:0] dev;
    logic [7:0] index;
  } cmd_t;

  localparam int OFS_BUF   = 'h008;
  localparam int OFS_SETUP = 'h010;
  localparam int OFS_CTRL  = 'h020;
  localparam int OFS_PARAM = 'h040;
  localparam int OFS_STAT  = 'h070;

  localparam logic [15:0] OPC_RD_AT  = 16'h0001;
  localparam logic [15:0] OPC_WR_AT  = 16'h4001;
  localparam logic [15:0] OPC_RD_DIR = 16'h1001;
  localparam logic [15:0] OPC_WR_DIR = 16'h6001;

  localparam int CTL_START = 1;
  localparam int STB_BUSY  = 0;
  localparam int STB_NACK  = 2;
  localparam int STB_DONE  = 3;
  localparam int STB_BADOP = 9;

endpackage

// File: rtl/i2ce_lane_swap.sv
module i2ce_lane_swap #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NB = W / 8;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign dout[8*g +: 8] = din[8*(NB-1-g) +: 8];
  end
endmodule

// File: rtl/i2ce_store_alu.sv
module i2ce_store_alu
  import i2ce_pkg::*;
#(
  parameter int W = 32
) (
  input  store_op_e    op,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] din,
  output logic [W-1:0] nxt
);
  always_comb begin
    unique case (op)
      ST_AND:  nxt = cur & din;
      ST_OR:   nxt = cur | din;
      ST_PLAIN: nxt = din;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/i2ce_setup_dec.sv
module i2ce_setup_dec
  import i2ce_pkg::*;
(
  input  logic [31:0] word,
  output cmd_t        cmd,
  output logic        ok
);
  always_comb begin
    cmd = '0;
    ok  = 1'b1;
    unique case (word[31:16])
      OPC_RD_AT, OPC_WR_AT: begin
        cmd.is_read = (word[31:16] == OPC_RD_AT);
        cmd.dev     = word[14:8];
        cmd.index   = word[7:0];
      end
      OPC_RD_DIR, OPC_WR_DIR: begin
        cmd.is_read = (word[31:16] == OPC_RD_DIR);
        cmd.direct  = 1'b1;
        cmd.index   = word[15:8];
      end
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/i2ce_seq.sv
module i2ce_seq
  import i2ce_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  cmd_t       cmd,
  input  logic       cmd_ok,
  input  logic [7:0] wbyte,
  output logic       txn_valid,
  input  logic       txn_ready,
  output logic       txn_read,
  output logic       txn_direct,
  output logic [6:0] txn_dev,
  output logic [7:0] txn_index,
  output logic [7:0] txn_wbyte,
  input  logic       rsp_valid,
  output logic       rsp_ready,
  input  logic       rsp_nack,
  output logic       fin,
  output logic       fin_nack,
  output logic       fin_bad,
  output logic       fin_read
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_FAIL} state_e;

  state_e     st;
  cmd_t       cmd_q;
  logic [7:0] wb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cmd_q <= '0;
      wb_q  <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (launch) begin
          cmd_q <= cmd;
          wb_q  <= wbyte;
          st    <= cmd_ok ? S_ISSUE : S_FAIL;
        end
        S_ISSUE: if (txn_ready) st <= S_WAIT;
        S_WAIT:  if (rsp_valid) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign txn_valid  = (st == S_ISSUE);
  assign rsp_ready  = (st == S_WAIT);
  assign txn_read   = cmd_q.is_read;
  assign txn_direct = cmd_q.direct;
  assign txn_dev    = cmd_q.dev;
  assign txn_index  = cmd_q.index;
  assign txn_wbyte  = wb_q;
  assign fin        = (rsp_ready && rsp_valid) || (st == S_FAIL);
  assign fin_nack   = rsp_ready && rsp_valid && rsp_nack;
  assign fin_bad    = (st == S_FAIL);
  assign fin_read   = cmd_q.is_read;

  p_txn_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_index) && $stable(txn_dev)
      && $stable(txn_wbyte) && $stable(txn_read) && $stable(txn_direct));

  p_chan_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !rsp_ready);

  p_fin_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !txn_valid && !rsp_ready);
endmodule

// File: rtl/i2ce_top.sv
module i2ce_top
  import i2ce_pkg::*;
#(
  parameter int DW    = 32,
  parameter int OFS_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [OFS_W+1:0]     bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic                 txn_valid,
  input  logic                 txn_ready,
  output logic                 txn_read,
  output logic                 txn_direct,
  output logic [6:0]           txn_dev,
  output logic [7:0]           txn_index,
  output logic [7:0]           txn_wbyte,
  input  logic                 rsp_valid,
  output logic                 rsp_ready,
  input  logic                 rsp_nack,
  input  logic [7:0]           rsp_rbyte
);
  localparam int ADDR_W = OFS_W + 2;

  logic [OFS_W-1:0] ofs;
  store_op_e        op;
  logic [DW-1:0]    wr_log, rd_log, nxt_val;
  logic [DW-1:0]    buf_q, setup_q, param_q, ctrl_w, stat_w;
  logic             start_q, done_q, nack_q, bad_q;
  logic             wr_hit, launch;
  cmd_t             dec_cmd;
  logic             dec_ok;
  logic             fin, fin_nack, fin_bad, fin_read;

  assign ofs = bus_addr[OFS_W-1:0];
  assign op  = store_op_e'(bus_addr[ADDR_W-1 -: 2]);

  i2ce_lane_swap #(.W(DW)) u_wswap (.din(bus_wdata), .dout(wr_log));
  i2ce_lane_swap #(.W(DW)) u_rswap (.din(rd_log),    .dout(bus_rdata));

  always_comb begin
    ctrl_w            = '0;
    ctrl_w[CTL_START] = start_q;
    stat_w            = '0;
    stat_w[STB_BUSY]  = start_q;
    stat_w[STB_NACK]  = nack_q;
    stat_w[STB_DONE]  = done_q;
    stat_w[STB_BADOP] = bad_q;
  end

  always_comb begin
    unique case (ofs)
      OFS_W'(OFS_BUF):   rd_log = buf_q;
      OFS_W'(OFS_SETUP): rd_log = setup_q;
      OFS_W'(OFS_CTRL):  rd_log = ctrl_w;
      OFS_W'(OFS_PARAM): rd_log = param_q;
      OFS_W'(OFS_STAT):  rd_log = stat_w;
      default:           rd_log = '0;
    endcase
  end

  i2ce_store_alu #(.W(DW)) u_alu (
    .op(op), .cur(rd_log), .din(wr_log), .nxt(nxt_val)
  );

  i2ce_setup_dec u_dec (.word(setup_q[31:0]), .cmd(dec_cmd), .ok(dec_ok));

  assign wr_hit = bus_we && (op != ST_NONE);
  assign launch = wr_hit && (ofs == OFS_W'(OFS_CTRL)) && !start_q && nxt_val[CTL_START];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q   <= '0;
      setup_q <= '0;
      param_q <= '0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      nack_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      if (wr_hit && ofs == OFS_W'(OFS_BUF))   buf_q   <= nxt_val;
      if (wr_hit && ofs == OFS_W'(OFS_SETUP)) setup_q <= nxt_val;
      if (wr_hit && ofs == OFS_W'(OFS_PARAM)) param_q <= nxt_val;
      if (fin && fin_read && !fin_nack && !fin_bad) buf_q[7:0] <= rsp_rbyte;
      if (launch) begin
        start_q <= 1'b1;
        done_q  <= 1'b0;
        nack_q  <= 1'b0;
        bad_q   <= 1'b0;
      end else if (fin) begin
        start_q <= 1'b0;
        done_q  <= 1'b1;
        nack_q  <= nack_q | fin_nack;
        bad_q   <= bad_q | fin_bad;
      end
    end
  end

  i2ce_seq u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .cmd(dec_cmd), .cmd_ok(dec_ok),
    .wbyte(buf_q[7:0]),
    .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_read(txn_read),
    .txn_direct(txn_direct), .txn_dev(txn_dev), .txn_index(txn_index),
    .txn_wbyte(txn_wbyte), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_nack(rsp_nack), .fin(fin), .fin_nack(fin_nack), .fin_bad(fin_bad),
    .fin_read(fin_read)
  );

  p_busy_cover_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid || rsp_ready) |-> start_q);

  p_start_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !start_q && done_q);

  p_nack_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fin && fin_nack |=> nack_q && !start_q);

  p_bad_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fin && fin_bad |=> bad_q && !start_q && !txn_valid);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> (nack_q || !$past(nack_q)) && (bad_q || !$past(bad_q)));
endmodule

// File: tb/sim_i2ce_top.sv
module sim_i2ce_top;
  localparam int CLK_P = 10;
  localparam logic [13:0] A_BUF = 14'h0008, A_SET = 14'h0010, A_CTL = 14'h0020,
                          A_PAR = 14'h0040, A_STA = 14'h0070;
  localparam logic [13:0] AL_AND = 14'h1000, AL_OR = 14'h2000, AL_BAD = 14'h3000;

  typedef struct packed {
    logic [31:0] setup;
    logic [31:0] bufw;
    logic        nack;
    logic [7:0]  rbyte;
    logic        rd;
    logic        dir;
    logic [6:0]  dev;
    logic [7:0]  idx;
    logic [31:0] ebuf;
    logic [31:0] estat;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{32'h00012A05, 32'h11223344, 1'b0, 8'h5A, 1'b1, 1'b0, 7'h2A, 8'h05, 32'h1122335A, 32'h8},
    '{32'h40013C0F, 32'h000000A7, 1'b0, 8'h00, 1'b0, 1'b0, 7'h3C, 8'h0F, 32'h000000A7, 32'h8},
    '{32'h10011FEE, 32'hDEADBE00, 1'b0, 8'h3C, 1'b1, 1'b1, 7'h00, 8'h1F, 32'hDEADBE3C, 32'h8},
    '{32'h60010700, 32'h00000055, 1'b1, 8'h00, 1'b0, 1'b1, 7'h00, 8'h07, 32'h00000055, 32'hC},
    '{32'h00017F10, 32'hCAFEF00D, 1'b1, 8'h99, 1'b1, 1'b0, 7'h7F, 8'h10, 32'hCAFEF00D, 32'hC}
  };

  logic        clk = 0, rst_n = 0;
  logic        bus_we = 0;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        txn_valid, txn_ready = 0, txn_read, txn_direct;
  logic [6:0]  txn_dev;
  logic [7:0]  txn_index, txn_wbyte;
  logic        rsp_valid = 0, rsp_ready, rsp_nack = 0;
  logic [7:0]  rsp_rbyte = '0;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  i2ce_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txn_valid(txn_valid),
    .txn_ready(txn_ready), .txn_read(txn_read), .txn_direct(txn_direct),
    .txn_dev(txn_dev), .txn_index(txn_index), .txn_wbyte(txn_wbyte),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_nack(rsp_nack),
    .rsp_rbyte(rsp_rbyte)
  );

  function automatic logic [31:0] bsw(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr_raw(input logic [13:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    wr_raw(a, bsw(d));
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    bus_addr = a; #1;
    d = bsw(bus_rdata);
  endtask

  task automatic serve(input logic rdx, input logic dirx, input logic [6:0] devx,
                       input logic [7:0] idxx, input logic [7:0] wbx,
                       input logic nk, input logic [7:0] rb);
    int n = 0;
    while (!txn_valid && n < 50) begin @(negedge clk); n++; end
    chk("R3 txn_valid", {31'd0, txn_valid}, 32'd1);
    chk("R3 read", {31'd0, txn_read}, {31'd0, rdx});
    chk("R3 direct", {31'd0, txn_direct}, {31'd0, dirx});
    chk("R3 dev", {25'd0, txn_dev}, {25'd0, devx});
    chk("R3 index", {24'd0, txn_index}, {24'd0, idxx});
    if (!rdx) chk("R7 wbyte", {24'd0, txn_wbyte}, {24'd0, wbx});
    repeat (2) @(negedge clk);
    chk("R11 hold", {txn_valid, txn_read, txn_direct, txn_dev, txn_index, 14'd0},
                    {1'b1, rdx, dirx, devx, idxx, 14'd0});
    txn_ready = 1;
    @(negedge clk);
    txn_ready = 0;
    chk("R11 rsp_ready", {30'd0, rsp_ready, txn_valid}, 32'h2);
    rsp_valid = 1; rsp_nack = nk; rsp_rbyte = rb;
    @(negedge clk);
    rsp_valid = 0; rsp_nack = 0;
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    rd(A_BUF, v); chk("R12 buf", v, 0);
    rd(A_SET, v); chk("R12 setup", v, 0);
    rd(A_CTL, v); chk("R12 ctrl", v, 0);
    rd(A_PAR, v); chk("R12 param", v, 0);
    rd(A_STA, v); chk("R12 status", v, 0);
    chk("R12 handshakes", {30'd0, txn_valid, rsp_ready}, 0);

    // vector table
    for (int i = 0; i < 5; i++) begin
      wr(A_SET, VEC[i].setup);
      wr(A_BUF, VEC[i].bufw);
      wr(AL_OR | A_CTL, 32'h2);
      rd(A_CTL, v); chk("R4 busy ctrl", v, 32'h2);
      rd(A_STA, v); chk("R10 cleared at launch", v, 32'h1);
      serve(VEC[i].rd, VEC[i].dir, VEC[i].dev, VEC[i].idx, VEC[i].bufw[7:0],
            VEC[i].nack, VEC[i].rbyte);
      rd(A_CTL, v); chk("R4 self clear", v, 0);
      rd(A_STA, v); chk("R8 status", v, VEC[i].estat);
      rd(A_BUF, v); chk("R7 buffer", v, VEC[i].ebuf);
    end

    // R10 error persists across idle cycles
    repeat (4) @(negedge clk);
    rd(A_STA, v); chk("R10 sticky", v, 32'hC);

    // R1 byte order
    wr(A_PAR, 32'h11223344);
    bus_addr = A_PAR; #1; chk("R1 raw load", bus_rdata, 32'h44332211);
    wr_raw(A_CTL, 32'h00000002);
    chk("R1 raw bit not start", {31'd0, txn_valid}, 0);
    rd(A_CTL, v); chk("R1 ctrl idle", v, 0);

    // R2 aliases
    wr(A_PAR, 32'hF0F01234);
    wr(AL_AND | A_PAR, 32'h0FF0FF00);
    rd(A_PAR, v); chk("R2 and", v, 32'h00F01200);
    wr(AL_OR | A_PAR, 32'h0000000F);
    rd(A_PAR, v); chk("R2 or", v, 32'h00F0120F);
    wr(AL_BAD | A_PAR, 32'h0);
    rd(A_PAR, v); chk("R2 alias 11 ignored", v, 32'h00F0120F);
    wr(A_STA, 32'hFFFFFFFF);
    rd(A_STA, v); chk("R2 status store ignored", v, 32'hC);

    // R9 unrecognised opcode, then R10 clear by next launch
    wr(A_SET, 32'h20010000);
    wr(A_CTL, 32'h2);
    chk("R9 no txn", {31'd0, txn_valid}, 0);
    @(negedge clk);
    rd(A_CTL, v); chk("R9 start cleared", v, 0);
    rd(A_STA, v); chk("R9 status", v, 32'h208);

    // R5 / R6 capture at launch, second start ignored
    wr(A_SET, 32'h40015522);
    wr(A_BUF, 32'h00000077);
    wr(A_CTL, 32'h2);
    rd(A_STA, v); chk("R10 bad cleared", v, 32'h1);
    wr(A_SET, 32'h10010900);
    wr(A_BUF, 32'h00000088);
    wr(AL_OR | A_CTL, 32'h2);
    serve(1'b0, 1'b0, 7'h55, 8'h22, 8'h77, 1'b0, 8'h00);
    rd(A_SET, v); chk("R5 setup store kept", v, 32'h10010900);
    rd(A_BUF, v); chk("R5 buffer store kept", v, 32'h88);
    begin
      int seen = 0;
      repeat (6) begin @(negedge clk); if (txn_valid) seen++; end
      chk("R6 no second txn", seen, 0);
    end
    rd(A_STA, v); chk("R6 status done", v, 32'h8);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule